// File: doc/BRIEF.md
# I2C Slave Address Matcher with General Call

This block is the receive front end of an I2C slave. It watches the already synchronised SCL and SDA lines and detects START and STOP conditions. After a START it shifts in the first byte MSb first. It then compares that byte with the programmed own address and with the fixed general-call address. When the byte is accepted, the block pulls SDA low on the ninth clock, copies the byte into a receive buffer, marks the buffer full and raises an interrupt flag for the host. Data bytes that follow an accepted write address are handled in the same way.

In 10-bit mode the address arrives in two stages. The first byte carries a fixed header and the two upper address bits. Accepting it raises an update-address request. The host services that request by pulsing a reload strobe, and only then can the second byte, which carries the lower eight address bits, be matched. A general call received in 10-bit mode skips the second stage and goes straight to data. Slave transmit and clock stretching are not part of this block.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `sda_pull_o`, `buf_full_o`, `upd_addr_o`, `ovf_o`, `irq_o` and `rx_data_o` are all zero.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, bytes are ignored (no ACK, no buffer or flag change) until the next START.
- R3: In 7-bit mode, a first byte whose bits [7:1] equal `own_addr_i[6:0]` is accepted. It is ACKed by driving `sda_pull_o` high through the ninth SCL high phase, it is copied whole into `rx_data_o` with R/W in bit 0, and `buf_full_o` is set at the eighth SCL rise. A mismatching byte is NACKed, and the rest of the transfer is ignored.
- R4: The byte 0x00 is accepted as a general call only when `gc_en_i` is 1. An own address of zero never matches.
- R5: `irq_o` is set on the falling edge of the ninth clock of every ACKed byte, is still 0 during that ninth high phase, and is cleared only by `irq_clr_i`.
- R6: After an accepted address with R/W = 0, each following data byte is ACKed and buffered. After an accepted 7-bit address with R/W = 1, the following bytes are ignored.
- R7: In 10-bit mode, a first byte of the form 11110, `own_addr_i[9:8]`, 0 is ACKed and buffered, and it sets `upd_addr_o`.
- R8: The second 10-bit byte is accepted only if it equals `own_addr_i[7:0]` and `upd_addr_o` has already been cleared by `addr_reload_i`. Otherwise it is NACKed and the transfer is ignored.
- R9: A general call received in 10-bit mode leaves `upd_addr_o` clear, and the next bytes are treated as data.
- R10: When a byte that would be accepted completes while `buf_full_o` is set, `ovf_o` is set, the byte is NACKed and `rx_data_o` keeps its old value. `ovf_o` is cleared only by `ovf_clr_i`.
- R11: A one-cycle `buf_rd_i` pulse clears `buf_full_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| own_addr_i | input | 10 | Own slave address (7-bit mode uses bits [6:0]) |
| gc_en_i | input | 1 | Enables general-call recognition |
| ten_bit_i | input | 1 | Selects 10-bit addressing |
| buf_rd_i | input | 1 | Host read strobe, clears buffer-full |
| irq_clr_i | input | 1 | Host clear of the interrupt flag |
| ovf_clr_i | input | 1 | Host clear of the overflow flag |
| addr_reload_i | input | 1 | Host strobe signalling the address was reloaded, clears update-address |
| sda_pull_o | output | 1 | SDA pull-down enable (ACK) |
| rx_data_o | output | 8 | Receive buffer |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| upd_addr_o | output | 1 | 10-bit update-address request |
| ovf_o | output | 1 | Receive overflow flag |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench targets the cases where the block decides whether to drive ACK. A second 10-bit byte that arrives before the reload strobe must be NACKed; a design that skipped this check would claim a transfer it was not yet configured for. The all-zero byte must be NACKed with general call disabled and with a zero own address; a design that matched it anyway would answer broadcasts it should ignore. A byte arriving on a full buffer must be NACKed and must leave the buffer intact; a design that got this wrong would silently lose the unread byte. The bench also checks that the interrupt flag stays low during the ninth high phase, so a flag raised at the wrong edge is caught, and it checks that read-address transfers and post-STOP traffic draw no ACK.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int ADDR10_W = 10;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR2,
        RX_DATA
    } rx_st_e;

    typedef struct packed {
        rx_st_e             st;
        rx_st_e             nxt;
        logic [BYTE_W-1:0]  shr;
        logic [CNT_W-1:0]   cnt;
        logic               ack;
        logic               in_ack;
        logic               drv;
        logic [BYTE_W-1:0]  rx;
        logic               bf;
        logic               ua;
        logic               ovf;
        logic               irq;
    } regs_t;
endpackage

// File: rtl/i2cam_line_mon.sv
module i2cam_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2cam_addr_cmp.sv
module i2cam_addr_cmp
    import i2cam_pkg::*;
(
    input  logic [BYTE_W-1:0]   rx_byte_i,
    input  logic [ADDR10_W-1:0] own_addr_i,
    input  logic                gc_en_i,
    input  logic                ten_bit_i,
    input  logic                ua_i,
    input  rx_st_e              st_i,
    output logic                accept_o,
    output logic                hdr10_o,
    output rx_st_e              nxt_o
);
    localparam logic [4:0] HDR10 = 5'b11110;

    logic gc_hit, m7_hit, m10a_hit, m10b_hit;

    always_comb begin
        gc_hit   = gc_en_i && (rx_byte_i == '0);
        m7_hit   = !ten_bit_i && (rx_byte_i[BYTE_W-1:1] == own_addr_i[6:0])
                   && (|rx_byte_i[BYTE_W-1:1]);
        m10a_hit = ten_bit_i && (rx_byte_i[7:3] == HDR10)
                   && (rx_byte_i[2:1] == own_addr_i[9:8]) && !rx_byte_i[0];
        m10b_hit = !ua_i && (rx_byte_i == own_addr_i[7:0]);

        accept_o = 1'b0;
        hdr10_o  = 1'b0;
        nxt_o    = RX_IDLE;
        case (st_i)
            RX_ADDR: begin
                if (gc_hit) begin
                    accept_o = 1'b1;
                    nxt_o    = RX_DATA;
                end else if (m7_hit) begin
                    accept_o = 1'b1;
                    nxt_o    = rx_byte_i[0] ? RX_IDLE : RX_DATA;
                end else if (m10a_hit) begin
                    accept_o = 1'b1;
                    hdr10_o  = 1'b1;
                    nxt_o    = RX_ADDR2;
                end
            end
            RX_ADDR2: begin
                if (m10b_hit) begin
                    accept_o = 1'b1;
                    nxt_o    = RX_DATA;
                end
            end
            RX_DATA: begin
                accept_o = 1'b1;
                nxt_o    = RX_DATA;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2cam_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [ADDR10_W-1:0] own_addr_i,
    input  logic                gc_en_i,
    input  logic                ten_bit_i,
    input  logic                buf_rd_i,
    input  logic                irq_clr_i,
    input  logic                ovf_clr_i,
    input  logic                addr_reload_i,
    output logic                sda_pull_o,
    output logic [BYTE_W-1:0]   rx_data_o,
    output logic                buf_full_o,
    output logic                upd_addr_o,
    output logic                ovf_o,
    output logic                irq_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    regs_t d, q;
    logic  scl_rise, scl_fall, start_det, stop_det;
    logic  cmp_accept, cmp_hdr10;
    rx_st_e cmp_nxt;
    logic [BYTE_W-1:0] rx_byte;

    i2cam_line_mon mon_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    assign rx_byte = {q.shr[BYTE_W-2:0], sda_i};

    i2cam_addr_cmp cmp_i (
        .rx_byte_i  (rx_byte),
        .own_addr_i (own_addr_i),
        .gc_en_i    (gc_en_i),
        .ten_bit_i  (ten_bit_i),
        .ua_i       (q.ua),
        .st_i       (q.st),
        .accept_o   (cmp_accept),
        .hdr10_o    (cmp_hdr10),
        .nxt_o      (cmp_nxt)
    );

    always_comb begin
        d = q;
        // host side clears; bus-side sets below take priority
        if (buf_rd_i)      d.bf  = 1'b0;
        if (irq_clr_i)     d.irq = 1'b0;
        if (ovf_clr_i)     d.ovf = 1'b0;
        if (addr_reload_i) d.ua  = 1'b0;

        if (stop_det) begin
            d.st     = RX_IDLE;
            d.cnt    = '0;
            d.in_ack = 1'b0;
            d.drv    = 1'b0;
        end else if (start_det) begin
            d.st     = RX_ADDR;
            d.cnt    = '0;
            d.in_ack = 1'b0;
            d.drv    = 1'b0;
        end else if (q.st != RX_IDLE) begin
            if (scl_rise && (q.cnt < ALL_BITS)) begin
                d.shr = rx_byte;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == LAST_BIT) begin
                    if (cmp_accept && q.bf) begin
                        d.ovf = 1'b1;
                        d.ack = 1'b0;
                        d.nxt = (q.st == RX_DATA) ? RX_DATA : RX_IDLE;
                    end else if (cmp_accept) begin
                        d.rx  = rx_byte;
                        d.bf  = 1'b1;
                        d.ack = 1'b1;
                        d.nxt = cmp_nxt;
                        if (cmp_hdr10) d.ua = 1'b1;
                    end else begin
                        d.ack = 1'b0;
                        d.nxt = RX_IDLE;
                    end
                end
            end else if (scl_fall && (q.cnt == ALL_BITS)) begin
                if (!q.in_ack) begin
                    d.in_ack = 1'b1;
                    d.drv    = q.ack;
                end else begin
                    d.in_ack = 1'b0;
                    d.drv    = 1'b0;
                    d.cnt    = '0;
                    d.st     = q.nxt;
                    if (q.ack) d.irq = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, nxt: RX_IDLE, shr: '0, cnt: '0, ack: 1'b0,
                   in_ack: 1'b0, drv: 1'b0, rx: '0, bf: 1'b0, ua: 1'b0,
                   ovf: 1'b0, irq: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.drv;
    assign rx_data_o  = q.rx;
    assign buf_full_o = q.bf;
    assign upd_addr_o = q.ua;
    assign ovf_o      = q.ovf;
    assign irq_o      = q.irq;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       ten_bit_i,
    input logic       sda_pull_o,
    input logic [7:0] rx_data_o,
    input logic       buf_full_o,
    input logic       upd_addr_o,
    input logic       ovf_o,
    input logic       irq_o
);
    // R5: interrupt appears just after an SCL falling edge
    a_r5_irq_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (!$past(scl_i) && $past(scl_i, 2)));

    // R3: ACK drive starts only while SCL is low
    a_r3_ack_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    // R3: buffer-full rises during an SCL high phase (eighth rise)
    a_r3_bf_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o) |-> scl_i);

    // R10: overflow keeps the old buffer and needs a full buffer
    a_r10_ovf_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> ($stable(rx_data_o) && buf_full_o));

    // R7: update-address request only in 10-bit mode
    a_r7_ua_ten_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_addr_o) |-> ten_bit_i);
endmodule

bind i2c_addr_match i2c_addr_match_chk chk_i (.*);

// File: tb/i2c_addr_match_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_match_tb_top;
    localparam int HP = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [9:0] own_addr = '0;
    logic       gc_en = 1'b0, ten_bit = 1'b0;
    logic       buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0, reload = 1'b0;
    logic       sda_pull, bf, ua, ovf, irq;
    logic [7:0] rxd;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_addr_match dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .own_addr_i(own_addr), .gc_en_i(gc_en), .ten_bit_i(ten_bit),
        .buf_rd_i(buf_rd), .irq_clr_i(irq_clr), .ovf_clr_i(ovf_clr),
        .addr_reload_i(reload), .sda_pull_o(sda_pull), .rx_data_o(rxd),
        .buf_full_o(bf), .upd_addr_o(ua), .ovf_o(ovf), .irq_o(irq)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // reference state: 0 idle, 1 address, 2 second address, 3 data
    int       m_st = 0;
    logic [7:0] m_buf = '0;
    bit m_bf, m_ua, m_ovf, m_irq, m_ack;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_byte(logic [7:0] b);
        bit acc = 0, hdr = 0;
        int nxt = 0;
        m_ack = 0;
        if (m_st == 0) return;
        case (m_st)
            1: begin
                if (gc_en && b == 8'h00) begin acc = 1; nxt = 3; end
                else if (!ten_bit && b[7:1] == own_addr[6:0] && b[7:1] != 0) begin
                    acc = 1; nxt = b[0] ? 0 : 3;
                end else if (ten_bit && b[7:3] == 5'b11110 && b[2:1] == own_addr[9:8] && !b[0]) begin
                    acc = 1; hdr = 1; nxt = 2;
                end
            end
            2: if (!m_ua && b == own_addr[7:0]) begin acc = 1; nxt = 3; end
            default: begin acc = 1; nxt = 3; end
        endcase
        if (acc && m_bf) begin
            m_ovf = 1;
            m_st  = (m_st == 3) ? 3 : 0;
        end else if (acc) begin
            m_buf = b; m_bf = 1; m_ack = 1; m_irq = 1;
            if (hdr) m_ua = 1;
            m_st = nxt;
        end else begin
            m_st = 0;
        end
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(HP);
        m_st = 1;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(HP);
        m_st = 0;
    endtask

    task automatic xfer(logic [7:0] b, string req);
        logic got_ack, irq_mid;
        bit   prev_irq;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HP);
            scl_m = 1'b1; tick(HP);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(2);
        got_ack = ~sda_bus;
        irq_mid = irq;
        tick(HP - 2);
        scl_m = 1'b0; tick(4);
        prev_irq = m_irq;
        model_byte(b);
        chk(req, "ack", int'(got_ack), int'(m_ack));
        chk({req, "/R5"}, "irq_in_ninth_high", int'(irq_mid), int'(prev_irq));
        chk(req, "buf_full", int'(bf), int'(m_bf));
        chk(req, "rx_data", int'(rxd), int'(m_buf));
        chk(req, "ovf", int'(ovf), int'(m_ovf));
        chk(req, "upd_addr", int'(ua), int'(m_ua));
        chk(req, "irq", int'(irq), int'(m_irq));
    endtask

    task automatic host_read();
        buf_rd = 1'b1; tick(1); buf_rd = 1'b0; tick(1);
        m_bf = 0;
        chk("R11", "buf_full_after_read", int'(bf), 0);
    endtask

    task automatic host_irq_clr();
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
        m_irq = 0;
        chk("R5", "irq_after_clear", int'(irq), 0);
    endtask

    task automatic host_ovf_clr();
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(1);
        m_ovf = 0;
        chk("R10", "ovf_after_clear", int'(ovf), 0);
    endtask

    task automatic host_reload();
        reload = 1'b1; tick(1); reload = 1'b0; tick(1);
        m_ua = 0;
        chk("R8", "upd_addr_after_reload", int'(ua), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog req=all actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        tick(5);
        // R1 reset state
        chk("R1", "sda_pull", int'(sda_pull), 0);
        chk("R1", "buf_full", int'(bf), 0);
        chk("R1", "upd_addr", int'(ua), 0);
        chk("R1", "ovf", int'(ovf), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "rx_data", int'(rxd), 0);
        rst_n = 1'b1; tick(4);

        // R3 R6 R5: 7-bit write match then data
        own_addr = 10'h052;
        bus_start();
        xfer(8'hA4, "R3");
        host_read();
        chk("R5", "irq_holds_until_clear", int'(irq), 1);
        host_irq_clr();
        xfer(8'h3C, "R6");
        // R10 overflow: buffer not read
        xfer(8'h7E, "R10");
        chk("R10", "buf_kept", int'(rxd), 8'h3C);
        host_ovf_clr();
        host_read();
        bus_stop();
        // R2 bytes after STOP are ignored
        xfer(8'hA4, "R2");
        // R3 mismatch, remaining bytes ignored
        bus_start();
        xfer(8'hA6, "R3");
        xfer(8'h55, "R3");
        bus_stop();
        // R4 general call gating
        bus_start(); xfer(8'h00, "R4"); bus_stop();
        gc_en = 1'b1;
        bus_start(); xfer(8'h00, "R4"); host_read(); xfer(8'h99, "R4"); host_read(); bus_stop();
        gc_en = 1'b0; own_addr = 10'h000;
        bus_start(); xfer(8'h00, "R4"); bus_stop();
        // R6 read address: following bytes ignored
        own_addr = 10'h052;
        bus_start(); xfer(8'hA5, "R6"); host_read(); xfer(8'h12, "R6"); bus_stop();
        host_irq_clr();

        // R7 R8 10-bit two-stage address
        ten_bit = 1'b1; own_addr = 10'h2B5;
        bus_start();
        xfer(8'hF4, "R7");
        host_read();
        xfer(8'hB5, "R8");
        bus_start();
        xfer(8'hF4, "R7");
        host_read();
        host_reload();
        xfer(8'hB5, "R8");
        host_read();
        xfer(8'h11, "R8");
        host_read();
        bus_stop();
        // R7 header with wrong upper bits
        bus_start(); xfer(8'hF2, "R7"); bus_stop();
        // R9 general call in 10-bit mode
        gc_en = 1'b1;
        bus_start(); xfer(8'h00, "R9"); host_read(); xfer(8'h5A, "R9"); host_read(); bus_stop();
        chk("R9", "upd_addr_clear", int'(ua), 0);
        host_irq_clr();
        ten_bit = 1'b0;

        // random 7-bit traffic
        r = $urandom(32'd20240611);
        for (int t = 0; t < 40; t++) begin
            own_addr = {3'b000, 7'(($urandom % 127) + 1)};
            gc_en = 1'($urandom % 2);
            bus_start();
            r = $urandom % 10;
            if (r < 5)      xfer({own_addr[6:0], 1'($urandom % 2)}, "R3");
            else if (r < 7) xfer(8'h00, "R4");
            else            xfer(8'($urandom), "R3");
            for (int k = 0; k < int'($urandom % 4); k++) begin
                if ($urandom % 2) host_read();
                xfer(8'($urandom), "R6");
                if ($urandom % 3 == 0) host_ovf_clr();
            end
            if ($urandom % 2) host_irq_clr();
            bus_stop();
            if ($urandom % 2) host_read();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule